// File: doc/BRIEF.md
# Audio Sample Input Formatter

This block sits between a bus-side data port and an audio serializer. Software or a DMA engine writes 32-bit words into it. For each word the block picks the bytes that make up one sample, reorders them as the endian setting asks, keeps the valid bits chosen by the justification and width settings, and places the result at the top of a 24-bit audio slot. The formatted sample and a left/right channel tag are then held in a small FIFO. The serializer pops one sample per request and sees it one cycle later. If the FIFO is empty at that moment, the serializer gets a null frame instead.

The settings are plain inputs. A single pulse on the clear input drains the FIFO. Ready, empty, full and chunk status tell the writer how much it may send in one burst. Two sticky flags, overflow and underrun, record a lost write and a starved read. The channel tag is assigned in one of three ways: from a dedicated input, by alternating on successive writes, or by alternating on successive reads.

Top module: `audio_fmt`

## Requirements
- R1: After reset the FIFO is empty. The outputs st_empty and st_ready are 1. The outputs st_full, st_chunk (when cfg_chunk is larger than DEPTH), st_overflow, st_underrun and out_valid are 0.
- R2: A sample's container is the low n bytes of wr_data, where n = cfg_bytes_m1 + 1 (1 to 4). With cfg_big_endian = 1 the byte order inside the container is reversed: container byte i is wr_data byte n-1-i.
- R3: The valid width v is cfg_valid_bits. If that field is 0 or larger than 8n, v is taken as 8n; widths 8, 16, 18, 20, 24 and 32 are all accepted. With cfg_msb_just = 0 the sample is container bits v-1..0. With cfg_msb_just = 1 the sample is the top v bits of the container.
- R4: The sample's top bit lands on out_sample bit 23. When v < 24 the lower bits are zero. When v > 24 the v-24 least significant bits are dropped. The sample appears with out_valid = 1 on the cycle after the rd_req cycle.
- R5: With cfg_dual = 0 every channel tag is 0. With cfg_dual = 1 the tag depends on cfg_mode:
  - Mode 0 takes the tag from wr_chan.
  - Mode 1 alternates the tag 0,1,0,... over accepted writes.
  - Modes 2 and 3 alternate the tag 0,1,0,... over successful reads.
- R6: A write while the FIFO holds DEPTH samples is dropped and sets st_overflow. That flag stays set until a clear.
- R7: An rd_req while the FIFO is empty gives, on the next cycle, out_valid = 1, out_null = 1, out_sample = 0 and out_chan = 0. It also sets st_underrun, which stays set until a clear.
- R8: st_full means the FIFO holds DEPTH samples, and st_ready is its inverse. st_empty means it holds none. st_chunk means the free slots number at least cfg_chunk, with a chunk of 0 counted as 1.
- R9: fifo_clear empties the FIFO. It clears both sticky flags and both channel alternations, so the next tag is 0. A write or read in the clear cycle has no effect, and out_valid is 0 on the next cycle.
- R10: Samples leave in write order. A write and a read in the same cycle are both judged against the FIFO state before that cycle: a full FIFO drops the write, and an empty FIFO underruns the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_big_endian | input | 1 | 1 reverses byte order inside the container |
| cfg_msb_just | input | 1 | 1 takes valid bits from the top of the container |
| cfg_bytes_m1 | input | 2 | Bytes per sample minus one |
| cfg_valid_bits | input | 6 | Valid bits per sample |
| cfg_dual | input | 1 | 1 for two channels, 0 for mono |
| cfg_mode | input | 2 | Channel steering: 0 indexed, 1 toggle on write, 2/3 alternate on read |
| cfg_chunk | input | 4 | Burst size for the chunk status |
| wr_en | input | 1 | Write strobe for wr_data |
| wr_data | input | 32 | Written data word |
| wr_chan | input | 1 | Channel tag used in indexed mode |
| fifo_clear | input | 1 | Empties the FIFO and clears sticky state |
| rd_req | input | 1 | Serializer request for one sample |
| out_valid | output | 1 | Response to the previous cycle's request |
| out_sample | output | 24 | Left-aligned sample |
| out_chan | output | 1 | Channel tag of the sample |
| out_null | output | 1 | Null frame because of underrun |
| st_ready | output | 1 | FIFO can accept a write |
| st_empty | output | 1 | FIFO holds no sample |
| st_full | output | 1 | FIFO holds DEPTH samples |
| st_chunk | output | 1 | Free space covers one chunk |
| st_overflow | output | 1 | Sticky: a write was dropped |
| st_underrun | output | 1 | Sticky: a read found no sample |

## Verification
The state that can go wrong internally is the FIFO count, the pointers and the two channel alternation bits.

A count error shows at once in st_empty, st_full or st_chunk, on the cycle right after the write or read that caused it. A pointer slip or a bad alternation bit shows only on the next sample popped: its value or channel tag is wrong one cycle after rd_req. A missed clear shows as a sticky flag or a stale tag that survives into the next stream.

// File: rtl/afmt_pkg.sv
package afmt_pkg;
    localparam int WORD_W = 32;
    localparam int SLOT_W = 24;

    localparam logic [1:0] MODE_INDEXED = 2'd0;
    localparam logic [1:0] MODE_TOGGLE  = 2'd1;

    typedef struct packed {
        logic              chan;
        logic [SLOT_W-1:0] smp;
    } slot_t;
endpackage

// File: rtl/afmt_format.sv
module afmt_format
    import afmt_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              big,
    input  logic              msb,
    input  logic [1:0]        bm1,
    input  logic [5:0]        vbits,
    output logic [SLOT_W-1:0] smp
);
    logic [5:0]        nbits;
    logic [5:0]        vb;
    logic [WORD_W-1:0] cont;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] just;
    logic [1:0]        src;

    always_comb begin
        nbits = {1'b0, bm1, 3'b000} + 6'd8;
        vb    = (vbits == 6'd0 || vbits > nbits) ? nbits : vbits;
        cont  = '0;
        src   = 2'd0;
        for (int i = 0; i < 4; i++) begin
            src = big ? 2'(bm1 - 2'(i)) : 2'(i);
            if (2'(i) <= bm1) begin
                cont[8*i +: 8] = word[8*src +: 8];
            end
        end
        mask = (vb == 6'd32) ? '1 : ((32'd1 << vb) - 32'd1);
        just = msb ? (cont >> (nbits - vb)) : (cont & mask);
        smp  = SLOT_W'((vb <= 6'd24) ? (just << (6'd24 - vb)) : (just >> (vb - 6'd24)));
    end
endmodule

// File: rtl/afmt_fifo.sv
module afmt_fifo
    import afmt_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clr,
    input  logic    push,
    input  logic    pop,
    input  slot_t   din,
    output slot_t   dout,
    output logic [AW:0] count
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    slot_t    mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (push) st_d.wp = st_q.wp + 1'b1;
            if (pop)  st_d.rp = st_q.rp + 1'b1;
            case ({push, pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[st_q.wp] <= din;
    end

    assign dout  = mem[st_q.rp];
    assign count = st_q.cnt;
endmodule

// File: rtl/audio_fmt.sv
module audio_fmt
    import afmt_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_big_endian,
    input  logic              cfg_msb_just,
    input  logic [1:0]        cfg_bytes_m1,
    input  logic [5:0]        cfg_valid_bits,
    input  logic              cfg_dual,
    input  logic [1:0]        cfg_mode,
    input  logic [3:0]        cfg_chunk,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_chan,
    input  logic              fifo_clear,
    input  logic              rd_req,
    output logic              out_valid,
    output logic [SLOT_W-1:0] out_sample,
    output logic              out_chan,
    output logic              out_null,
    output logic              st_ready,
    output logic              st_empty,
    output logic              st_full,
    output logic              st_chunk,
    output logic              st_overflow,
    output logic              st_underrun
);
    typedef struct packed {
        logic              tog;
        logic              rtog;
        logic              ovf;
        logic              udr;
        logic              ov;
        logic              onull;
        logic              ochan;
        logic [SLOT_W-1:0] osmp;
    } top_st_t;

    top_st_t     st_d, st_q;
    logic [AW:0] cnt;
    logic        full, empty, do_push, do_pop, rd_alt;
    slot_t       wslot, rslot;
    logic [31:0] free_w, thr_w;

    afmt_format u_fmt (
        .word  (wr_data),
        .big   (cfg_big_endian),
        .msb   (cfg_msb_just),
        .bm1   (cfg_bytes_m1),
        .vbits (cfg_valid_bits),
        .smp   (wslot.smp)
    );

    afmt_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clear),
        .push  (do_push),
        .pop   (do_pop),
        .din   (wslot),
        .dout  (rslot),
        .count (cnt)
    );

    always_comb begin
        full    = (32'(cnt) == 32'(DEPTH));
        empty   = (cnt == '0);
        do_push = wr_en && !fifo_clear && !full;
        do_pop  = rd_req && !fifo_clear && !empty;
        rd_alt  = cfg_dual && cfg_mode[1];
        free_w  = 32'(DEPTH) - 32'(cnt);
        thr_w   = (cfg_chunk == 4'd0) ? 32'd1 : 32'(cfg_chunk);

        if (!cfg_dual || cfg_mode[1]) wslot.chan = 1'b0;
        else if (cfg_mode == MODE_INDEXED) wslot.chan = wr_chan;
        else wslot.chan = st_q.tog;

        st_d    = st_q;
        st_d.ov = 1'b0;
        if (fifo_clear) begin
            st_d.tog   = 1'b0;
            st_d.rtog  = 1'b0;
            st_d.ovf   = 1'b0;
            st_d.udr   = 1'b0;
            st_d.onull = 1'b0;
        end else begin
            if (wr_en && full) st_d.ovf = 1'b1;
            if (do_push && cfg_dual && cfg_mode == MODE_TOGGLE) st_d.tog = !st_q.tog;
            if (rd_req) begin
                st_d.ov = 1'b1;
                if (empty) begin
                    st_d.onull = 1'b1;
                    st_d.osmp  = '0;
                    st_d.ochan = 1'b0;
                    st_d.udr   = 1'b1;
                end else begin
                    st_d.onull = 1'b0;
                    st_d.osmp  = rslot.smp;
                    st_d.ochan = rd_alt ? st_q.rtog : rslot.chan;
                    if (rd_alt) st_d.rtog = !st_q.rtog;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.ov;
    assign out_sample  = st_q.osmp;
    assign out_chan    = st_q.ochan;
    assign out_null    = st_q.onull;
    assign st_ready    = !full;
    assign st_empty    = empty;
    assign st_full     = full;
    assign st_chunk    = free_w >= thr_w;
    assign st_overflow = st_q.ovf;
    assign st_underrun = st_q.udr;
endmodule

// File: rtl/afmt_chk.sv
module afmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        fifo_clear,
    input logic        rd_req,
    input logic        out_valid,
    input logic        out_null,
    input logic [23:0] out_sample,
    input logic        st_empty,
    input logic        st_full,
    input logic        st_chunk,
    input logic        st_overflow,
    input logic        st_underrun
);
    // R8
    a_r8_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_full && st_empty));
    // R8
    a_r8_chunk_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        st_chunk |-> !st_full);
    // R6
    a_r6_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && st_full && !fifo_clear |=> st_overflow);
    // R6
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_overflow && !fifo_clear |=> st_overflow);
    // R7
    a_r7_null_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && st_empty && !fifo_clear |=> out_valid && out_null && out_sample == 24'd0 && st_underrun);
    // R7
    a_r7_udr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_underrun && !fifo_clear |=> st_underrun);
    // R9
    a_r9_clear_resets: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear |=> st_empty && !st_overflow && !st_underrun && !out_valid);
    // R4
    a_r4_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !fifo_clear |=> out_valid);
endmodule

bind audio_fmt afmt_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .fifo_clear  (fifo_clear),
    .rd_req      (rd_req),
    .out_valid   (out_valid),
    .out_null    (out_null),
    .out_sample  (out_sample),
    .st_empty    (st_empty),
    .st_full     (st_full),
    .st_chunk    (st_chunk),
    .st_overflow (st_overflow),
    .st_underrun (st_underrun)
);

// File: tb/sim_audio_fmt.sv
module sim_audio_fmt;
    localparam int CLK_NS = 10;
    localparam int DEPTH  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_big_endian = 0, cfg_msb_just = 0, cfg_dual = 0;
    logic [1:0]  cfg_bytes_m1 = 0, cfg_mode = 0;
    logic [5:0]  cfg_valid_bits = 0;
    logic [3:0]  cfg_chunk = 0;
    logic        wr_en = 0, wr_chan = 0, fifo_clear = 0, rd_req = 0;
    logic [31:0] wr_data = 0;
    logic        out_valid, out_chan, out_null;
    logic [23:0] out_sample;
    logic        st_ready, st_empty, st_full, st_chunk, st_overflow, st_underrun;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    logic [24:0] q[$];
    bit m_tog, m_rtog, m_ovf, m_udr, e_ov, e_null, e_chan;
    logic [23:0] e_smp;

    always #(CLK_NS/2) clk = ~clk;

    audio_fmt #(.DEPTH(DEPTH)) u0 (.*);

    function automatic logic [23:0] fmt_model(logic [31:0] w, bit big, bit msb,
                                              int bm1, int vbits);
        logic [23:0] r = '0;
        int n = bm1 + 1;
        int nb = 8 * n;
        int v = (vbits == 0 || vbits > nb) ? nb : vbits;
        for (int t = 23; t >= 0; t--) begin
            int j = t - 24 + v;
            if (j >= 0 && j < v) begin
                int k = msb ? j + nb - v : j;
                int idx = k / 8;
                int sb = big ? n - 1 - idx : idx;
                r[t] = w[8*sb + (k % 8)];
            end
        end
        return r;
    endfunction

    task automatic chk(logic [31:0] act, logic [31:0] exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit full = (q.size() == DEPTH);
        bit empty = (q.size() == 0);
        logic [24:0] head;
        bit wch;
        e_ov = 0;
        if (fifo_clear) begin
            q.delete();
            m_tog = 0; m_rtog = 0; m_ovf = 0; m_udr = 0; e_null = 0;
            return;
        end
        if (rd_req) begin
            e_ov = 1;
            if (empty) begin
                e_null = 1; e_smp = 0; e_chan = 0; m_udr = 1;
            end else begin
                head = q.pop_front();
                e_null = 0;
                e_smp = head[23:0];
                if (cfg_dual && cfg_mode >= 2) begin
                    e_chan = m_rtog; m_rtog = !m_rtog;
                end else e_chan = head[24];
            end
        end
        if (wr_en) begin
            if (full) m_ovf = 1;
            else begin
                if (!cfg_dual || cfg_mode >= 2) wch = 0;
                else if (cfg_mode == 0) wch = wr_chan;
                else begin wch = m_tog; m_tog = !m_tog; end
                q.push_back({wch, fmt_model(wr_data, cfg_big_endian, cfg_msb_just,
                                            cfg_bytes_m1, cfg_valid_bits)});
            end
        end
    endtask

    task automatic check_all();
        int thr = (cfg_chunk == 0) ? 1 : cfg_chunk;
        chk(st_empty, q.size() == 0, "R8 empty");
        chk(st_full, q.size() == DEPTH, "R8 full");
        chk(st_ready, q.size() != DEPTH, "R8 ready");
        chk(st_chunk, (DEPTH - q.size()) >= thr, "R8 chunk");
        chk(st_overflow, m_ovf, "R6 overflow flag");
        chk(st_underrun, m_udr, "R7 underrun flag");
        chk(out_valid, e_ov, "R4 out_valid timing");
        if (e_ov) begin
            chk(out_null, e_null, "R7 null frame");
            chk(out_chan, e_chan, "R5 channel tag");
            chk(out_sample, e_smp, "R2 R3 R4 R10 sample value");
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic idle_inputs();
        wr_en = 0; rd_req = 0; fifo_clear = 0;
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int vlist[6] = '{8, 16, 18, 20, 24, 32};
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(st_empty, 1, "R1 empty after reset");
        chk(st_ready, 1, "R1 ready after reset");
        chk(st_full, 0, "R1 full after reset");
        chk(st_overflow, 0, "R1 overflow after reset");
        chk(st_underrun, 0, "R1 underrun after reset");
        chk(out_valid, 0, "R1 out_valid after reset");
        cfg_chunk = 4'd15;
        #1 chk(st_chunk, 0, "R1 chunk larger than depth");

        // R2 directed: 3 bytes, big-endian, LSB justified, 24 bits
        cfg_bytes_m1 = 2; cfg_big_endian = 1; cfg_msb_just = 0; cfg_valid_bits = 24;
        cfg_chunk = 1;
        wr_en = 1; wr_data = 32'hFF123456; tick();
        idle_inputs(); rd_req = 1; tick();
        chk(out_sample, 24'h563412, "R2 big-endian 3-byte sample");
        idle_inputs();

        // R3 directed: 4 bytes, little, MSB justified, 20 bits
        cfg_bytes_m1 = 3; cfg_big_endian = 0; cfg_msb_just = 1; cfg_valid_bits = 20;
        wr_en = 1; wr_data = 32'hABCDE123; tick();
        idle_inputs(); rd_req = 1; tick();
        chk(out_sample, 24'hABCDE0, "R3 MSB justified 20-bit sample");
        // R4 directed: 32-bit LSB justified drops low byte
        cfg_msb_just = 0; cfg_valid_bits = 32;
        idle_inputs(); wr_en = 1; wr_data = 32'h87654321; tick();
        idle_inputs(); rd_req = 1; tick();
        chk(out_sample, 24'h876543, "R4 32-bit truncation");
        idle_inputs();

        // R6 fill past depth
        for (int i = 0; i < DEPTH + 2; i++) begin
            wr_en = 1; wr_data = 32'(i * 32'h01010101); tick();
        end
        idle_inputs();
        chk(st_overflow, 1, "R6 overflow after overfill");
        // R10 drain in order, R7 then underrun
        for (int i = 0; i < DEPTH + 1; i++) begin
            rd_req = 1; tick();
        end
        idle_inputs(); tick();
        chk(st_underrun, 1, "R7 underrun after overdrain");
        // R9 clear with a concurrent write ignored
        fifo_clear = 1; wr_en = 1; rd_req = 1; tick();
        idle_inputs(); tick();
        chk(st_empty, 1, "R9 write during clear ignored");

        // random segments
        for (int seg = 0; seg < 40; seg++) begin
            int wp = 20 + $urandom_range(0, 60);
            int rp = 20 + $urandom_range(0, 60);
            cfg_bytes_m1   = 2'($urandom_range(0, 3));
            cfg_valid_bits = ($urandom_range(0, 7) == 0) ? 6'($urandom_range(0, 63))
                                                          : 6'(vlist[$urandom_range(0, 5)]);
            cfg_big_endian = 1'($urandom_range(0, 1));
            cfg_msb_just   = 1'($urandom_range(0, 1));
            cfg_dual       = 1'($urandom_range(0, 1));
            cfg_mode       = 2'($urandom_range(0, 3));
            cfg_chunk      = 4'($urandom_range(0, 15));
            fifo_clear = 1; wr_en = 1'($urandom_range(0, 1)); rd_req = 1'($urandom_range(0, 1));
            tick();
            fifo_clear = 0;
            for (int c = 0; c < 200; c++) begin
                wr_en   = ($urandom_range(0, 99) < wp);
                rd_req  = ($urandom_range(0, 99) < rp);
                wr_data = $urandom();
                wr_chan = 1'($urandom_range(0, 1));
                tick();
            end
            idle_inputs();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule